// File: doc/BRIEF.md
# Interlocked Handshake Memory Target

This block is a small word store that sits on a fully interlocked, clockless bus and answers a single master. The master places an address and, for a write, a data word on the bus, drives the bus request, read strobe and direction lines low or high as needed, and then pulls its sync line low. The block runs on its own clock. It brings the four control lines into that clock domain through two-flop synchronizers, decides whether the address falls in its page, and after a configurable access delay pulls its own sync reply low. For a read, it drives the addressed word and enables its output only while that reply is low.

The reply stays low until the master's sync line is seen high again. The reply is then released and the block returns to idle, which closes the four-phase exchange. A cycle whose address or request does not select the block gets no reply. The block waits for the master to give up before it will look at the bus again.

The controller has four states. `ST_IDLE` waits for a synchronized master sync. It goes to `ST_WAIT` when the block is selected, and to `ST_SKIP` when it is not. `ST_WAIT` counts the access delay and then moves to `ST_ACK`. A write is committed on that transition. `ST_ACK` holds the reply low. `ST_ACK` and `ST_SKIP` both return to `ST_IDLE` once the master sync is seen high.

Top module: `hsk_mem_slave`

## Requirements
- R1: For a selected cycle, `ssync_n` falls exactly ACC_DLY+3 rising clock edges after `msync_n` falls. That is two synchronizer stages, one decision edge and ACC_DLY delay edges.
- R2: A selected cycle with `rw_n`=0 (write) stores `dat_in` into word `bus_addr[IDX_W-1:0]` exactly once. No other word changes.
- R3: A selected cycle with `rw_n`=1 and `rd_n`=0 (read) drives `dat_out` with the stored word at `bus_addr[IDX_W-1:0]` and holds `dat_oe`=1 for as long as `ssync_n` is low.
- R4: While `ssync_n` is high, `dat_oe` is 0 and `dat_out` is all zeros.
- R5: Once low, `ssync_n` stays low while `msync_n` is held low. It returns high exactly 3 rising edges after `msync_n` rises.
- R6: The block is selected only when `req_n`=0 and `bus_addr[AW-1:IDX_W]` equals PAGE. An unselected cycle never pulls `ssync_n` low and leaves every stored word unchanged, whatever the value of `rw_n`.
- R7: A selected cycle with `rw_n`=1 and `rd_n`=1 is acknowledged with the normal timing, drives no data and changes no word.
- R8: After reset, `ssync_n`=1, `dat_oe`=0, and every stored word reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | AW | Bus address: page in the upper bits, word index in the lower IDX_W bits |
| req_n | input | 1 | Active-low bus request |
| rd_n | input | 1 | Active-low read strobe |
| rw_n | input | 1 | Direction: 0 write, 1 read |
| msync_n | input | 1 | Active-low master sync |
| dat_in | input | DW | Write data from the master |
| dat_out | output | DW | Read data, zero when not driven |
| dat_oe | output | 1 | Read data enable |
| ssync_n | output | 1 | Active-low slave sync reply |

## Verification
The bench writes every word of the page with a distinct computed value, reads each one back, and measures the reply edges by counting clock edges. An off-by-one in the synchronizer or delay counter would show up as a wrong edge count. A controller that released the reply before the master had withdrawn would fail the hold check. Cycles are aimed at other pages, at the right page with the request high, and at the right page with both strobes idle. A decoder that ignored the page bits or the request would answer or corrupt a word, and the readback that follows would show it. Output enable and data are also checked between cycles, which catches data left driven after the reply is released.

// File: rtl/hsk_pkg.sv
package hsk_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_ACK  = 2'd2,
        ST_SKIP = 2'd3
    } hsk_state_t;
endpackage

// File: rtl/hsk_sync.sv
module hsk_sync #(
    parameter int          W       = 4,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic s1, s2;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s1 <= RST_VAL[i];
                s2 <= RST_VAL[i];
            end else begin
                s1 <= d[i];
                s2 <= s1;
            end
        end
        assign q[i] = s2;
    end
endmodule

// File: rtl/hsk_store.sv
module hsk_store #(
    parameter int DW    = 8,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DW-1:0] words [DEPTH];

    for (genvar w = 0; w < DEPTH; w++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                words[w] <= '0;
            else if (we && (idx == IDX_W'(w)))
                words[w] <= wdata;
        end
    end

    assign rdata = words[idx];
endmodule

// File: rtl/hsk_ctrl.sv
module hsk_ctrl
    import hsk_pkg::*;
#(
    parameter int ACC_DLY = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ms_s,
    input  logic sel,
    input  logic is_wr,
    input  logic is_rd,
    output logic cap,
    output logic mem_we,
    output logic ssync_n,
    output logic dat_oe
);
    localparam int              CNT_W = (ACC_DLY < 2) ? 1 : $clog2(ACC_DLY + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(ACC_DLY - 1);

    hsk_state_t       state, nxt;
    logic [CNT_W-1:0] cnt;
    logic             op_wr, op_rd;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (!ms_s) nxt = sel ? ST_WAIT : ST_SKIP;
            ST_WAIT: if (cnt == LAST) nxt = ST_ACK;
            ST_ACK:  if (ms_s) nxt = ST_IDLE;
            ST_SKIP: if (ms_s) nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            op_wr <= 1'b0;
            op_rd <= 1'b0;
        end else begin
            state <= nxt;
            if (cap) begin
                cnt   <= '0;
                op_wr <= is_wr;
                op_rd <= is_rd;
            end else if (state == ST_WAIT) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    always_comb begin
        cap     = (state == ST_IDLE) && !ms_s && sel;
        mem_we  = (state == ST_WAIT) && (cnt == LAST) && op_wr;
        ssync_n = (state != ST_ACK);
        dat_oe  = (state == ST_ACK) && op_rd;
    end

    AST_OE_IN_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        dat_oe |-> !ssync_n); // R4
    AST_SSYN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ssync_n && !ms_s) |=> !ssync_n); // R5
    AST_SSYN_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ssync_n) |-> $past(ms_s)); // R5
    AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we); // R2
    AST_ACK_NEEDS_MSYN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ssync_n) |-> !ms_s); // R1
endmodule

// File: rtl/hsk_mem_slave.sv
module hsk_mem_slave #(
    parameter int                AW      = 8,
    parameter int                DW      = 8,
    parameter int                IDX_W   = 4,
    parameter logic [AW-IDX_W-1:0] PAGE  = 'hA,
    parameter int                ACC_DLY = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic          req_n,
    input  logic          rd_n,
    input  logic          rw_n,
    input  logic          msync_n,
    input  logic [DW-1:0] dat_in,
    output logic [DW-1:0] dat_out,
    output logic          dat_oe,
    output logic          ssync_n
);
    localparam int NCTL = 4;

    logic [NCTL-1:0]  ctl_s;
    logic             ms_s, req_s, rd_s, rw_s;
    logic             sel, is_wr, is_rd, cap, mem_we;
    logic [IDX_W-1:0] idx_q;
    logic [DW-1:0]    wdat_q, rdata;

    hsk_sync #(.W(NCTL), .RST_VAL('1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({msync_n, req_n, rd_n, rw_n}),
        .q     (ctl_s)
    );

    assign {ms_s, req_s, rd_s, rw_s} = ctl_s;

    assign sel   = !req_s && (bus_addr[AW-1:IDX_W] == PAGE);
    assign is_wr = !rw_s;
    assign is_rd = rw_s && !rd_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q  <= '0;
            wdat_q <= '0;
        end else if (cap) begin
            idx_q  <= bus_addr[IDX_W-1:0];
            wdat_q <= dat_in;
        end
    end

    hsk_ctrl #(.ACC_DLY(ACC_DLY)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .ms_s    (ms_s),
        .sel     (sel),
        .is_wr   (is_wr),
        .is_rd   (is_rd),
        .cap     (cap),
        .mem_we  (mem_we),
        .ssync_n (ssync_n),
        .dat_oe  (dat_oe)
    );

    hsk_store #(.DW(DW), .IDX_W(IDX_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .idx   (idx_q),
        .wdata (wdat_q),
        .rdata (rdata)
    );

    assign dat_out = dat_oe ? rdata : '0;

    AST_DATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ssync_n |-> (dat_out == '0)); // R4
endmodule

// File: tb/hsk_mem_slave_test.sv
module hsk_mem_slave_test;
    localparam int ACC_DLY = 2;
    localparam logic [3:0] PAGE = 4'hA;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = '0;
    logic       req_n = 1'b1, rd_n = 1'b1, rw_n = 1'b1, msync_n = 1'b1;
    logic [7:0] dat_in = '0;
    logic [7:0] dat_out;
    logic       dat_oe, ssync_n;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;
    logic [7:0] model [16];

    always #2.5 clk = ~clk;

    hsk_mem_slave #(.AW(8), .DW(8), .IDX_W(4), .PAGE(PAGE), .ACC_DLY(ACC_DLY)) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .req_n(req_n), .rd_n(rd_n),
        .rw_n(rw_n), .msync_n(msync_n), .dat_in(dat_in), .dat_out(dat_out),
        .dat_oe(dat_oe), .ssync_n(ssync_n)
    );

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            mismatched++;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
            summary();
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One full bus cycle; drives at negedges, samples at negedges.
    task automatic xact(input logic [7:0] a, input logic rq, input logic rw, input logic rd,
                        input logic [7:0] wd, input logic exp_ack, input logic exp_oe,
                        input logic [7:0] exp_dat, input string req);
        int n;
        @(negedge clk);
        bus_addr = a; req_n = rq; rw_n = rw; rd_n = rd; dat_in = wd;
        @(negedge clk);
        msync_n = 1'b0;
        if (exp_ack) begin
            n = 0;
            do begin
                @(posedge clk); n++;
                @(negedge clk);
            end while (ssync_n && n < 20);
            chk("R1 reply latency", n, ACC_DLY + 3);
            chk({req, " data enable"}, dat_oe, exp_oe);
            chk({req, " data"}, dat_out, exp_oe ? exp_dat : 8'h00);
            repeat (3) @(negedge clk);
            chk("R5 reply held", ssync_n, 1'b0);
            chk({req, " enable held"}, dat_oe, exp_oe);
            msync_n = 1'b1;
            n = 0;
            do begin
                @(posedge clk); n++;
                @(negedge clk);
            end while (!ssync_n && n < 20);
            chk("R5 release latency", n, 3);
        end else begin
            n = 0;
            for (int k = 0; k < 12; k++) begin
                @(negedge clk);
                if (!ssync_n) n++;
            end
            chk("R6 no reply when unselected", n, 0);
            msync_n = 1'b1;
            repeat (5) @(negedge clk);
        end
        req_n = 1'b1; rd_n = 1'b1; rw_n = 1'b1;
        @(negedge clk);
        chk("R4 idle enable", dat_oe, 1'b0);
        chk("R4 idle data", dat_out, 8'h00);
    endtask

    task automatic readback(input string req);
        for (int i = 0; i < 16; i++)
            xact({PAGE, 4'(i)}, 1'b0, 1'b1, 1'b0, 8'h00, 1'b1, 1'b1, model[i], req);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) model[i] = 8'h00;
        repeat (3) @(negedge clk);
        chk("R8 reset reply", ssync_n, 1'b1);
        chk("R8 reset enable", dat_oe, 1'b0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        readback("R8 reset contents");

        for (int i = 0; i < 16; i++) begin
            logic [7:0] v;
            v = 8'(i * 37 + 5);
            xact({PAGE, 4'(i)}, 1'b0, 1'b0, 1'b1, v, 1'b1, 1'b0, 8'h00, "R2 write");
            model[i] = v;
        end
        readback("R3 read");

        // unselected: wrong page with write, right page with request idle
        for (int p = 0; p < 16; p++) begin
            if (4'(p) != PAGE)
                xact({4'(p), 4'(p)}, 1'b0, 1'b0, 1'b1, 8'hEE, 1'b0, 1'b0, 8'h00, "R6");
        end
        xact({PAGE, 4'd3}, 1'b1, 1'b0, 1'b1, 8'h99, 1'b0, 1'b0, 8'h00, "R6");
        xact({PAGE, 4'd4}, 1'b1, 1'b1, 1'b0, 8'h99, 1'b0, 1'b0, 8'h00, "R6");
        // null operation: both strobes idle
        xact({PAGE, 4'd5}, 1'b0, 1'b1, 1'b1, 8'h77, 1'b1, 1'b0, 8'h00, "R7 null op");
        readback("R6 R7 contents unchanged");

        // overwrite one word, neighbours stay
        xact({PAGE, 4'd15}, 1'b0, 1'b0, 1'b1, 8'h5A, 1'b1, 1'b0, 8'h00, "R2 overwrite");
        model[15] = 8'h5A;
        readback("R2 R3 after overwrite");

        summary();
    end
endmodule